// File: doc/BRIEF.md
# Debug Address-Match Unit

This block watches a processor's instruction fetches and its data loads and stores, and compares their addresses against a small bank of programmable match slots. Breakpoint slots compare the address of the instruction about to run. Watchpoint slots compare the byte address of a data access, and each one is armed for reads, for writes, for both, or not at all. A hit becomes a pending exception request. The request stays raised until the exception controller acknowledges it.

A watchpoint hit must stop the load or store before it changes memory. The block therefore raises a stall combinationally in the same cycle as the matching access. The stall stays high while the watchpoint request waits for its acknowledge. Breakpoint and watchpoint requests are registered one cycle after the hit. When both are pending, the breakpoint is presented first.

Top module: `dbg_match_unit`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `bp_req`, `wp_req` and `stall_access` are 0. Every breakpoint slot is disabled and every watchpoint mode is off.
- R2: A breakpoint slot is armed when bit 0 of its register is 1. Its compare address is the register with bit 0 cleared. When `fetch_valid` is high and `fetch_pc` equals that address, `bp_req` is 1 from the next cycle. With `fetch_valid` low there is no match.
- R3: The watchpoint mode encoding is 00 off, 01 reads only, 10 writes only and 11 reads and writes. A hit needs the access strobe (`mem_rd` or `mem_wr`) that the mode allows. A matching hit sets `wp_req` from the next cycle.
- R4: A watchpoint hit needs `mem_addr` to equal the slot's address register on all bits. A neighbouring byte address does not match.
- R5: A disabled slot never matches, whatever its address register holds. This covers a breakpoint with bit 0 clear and a watchpoint with mode 00.
- R6: `stall_access` is 1 in the same cycle as a data access that hits an armed watchpoint. It stays 1 for as long as a watchpoint request is pending.
- R7: A raised request stays at 1 until `req_ack` is sampled high while that request is presented.
- R8: When a breakpoint and a watchpoint are both pending, `bp_req` is 1 and `wp_req` is 0. The first acknowledge clears the breakpoint, and `wp_req` then shows the watchpoint. A second acknowledge clears the watchpoint.
- R9: Writing 0 to a breakpoint slot that is already disarmed changes nothing. The other slots keep matching as before.
- R10: `cfg_sel` selects the configuration register. Values 0 to NUM_BP-1 select the breakpoint slots. Values NUM_BP to NUM_BP+NUM_WP-1 select the watchpoint address registers. Value NUM_BP+NUM_WP selects the mode register, where watchpoint slot i uses bits [2i+1:2i]. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| fetch_valid | input | 1 | Instruction fetch address is valid |
| fetch_pc | input | ADDR_W | Address of the instruction about to execute |
| mem_addr | input | ADDR_W | Data access byte address |
| mem_rd | input | 1 | Data read strobe |
| mem_wr | input | 1 | Data write strobe |
| req_ack | input | 1 | Exception controller takes the presented request |
| bp_req | output | 1 | Breakpoint exception request |
| wp_req | output | 1 | Watchpoint exception request |
| stall_access | output | 1 | Hold the current data access before it completes |

## Verification
A breakpoint hit and a watchpoint hit can occur in the same cycle. The bench provokes this by presenting a fetch that matches breakpoint slot 0 and a read that matches watchpoint slot 0 on the same clock. It then checks four things:
- the stall is raised at once;
- only the breakpoint request shows after the edge;
- the watchpoint request appears only after the first acknowledge;
- both requests are clear after the second acknowledge.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
  typedef enum logic [1:0] {
    WP_OFF = 2'b00,
    WP_RD  = 2'b01,
    WP_WR  = 2'b10,
    WP_ANY = 2'b11
  } wp_mode_e;
endpackage

// File: rtl/dbg_bp_cmp.sv
module dbg_bp_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] slot_reg,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              hit
);
  // bit 0 of the slot register is the arm bit; compare address has bit 0 clear
  logic [ADDR_W-1:0] cmp_addr;
  assign cmp_addr = {slot_reg[ADDR_W-1:1], 1'b0};
  assign hit = fetch_valid & slot_reg[0] & (fetch_pc == cmp_addr);
endmodule

// File: rtl/dbg_wp_cmp.sv
module dbg_wp_cmp
  import dbg_match_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  wp_mode_e          mode,
  input  logic [ADDR_W-1:0] addr_reg,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic              hit
);
  logic kind_ok;
  always_comb begin
    case (mode)
      WP_RD:   kind_ok = mem_rd;
      WP_WR:   kind_ok = mem_wr;
      WP_ANY:  kind_ok = mem_rd | mem_wr;
      default: kind_ok = 1'b0;
    endcase
  end
  assign hit = kind_ok & (mem_addr == addr_reg);
endmodule

// File: rtl/dbg_req_hold.sv
module dbg_req_hold (
  input  logic clk,
  input  logic rst,
  input  logic bp_set,
  input  logic wp_set,
  input  logic req_ack,
  output logic bp_req,
  output logic wp_req,
  output logic wp_pend
);
  logic bp_pend;
  logic bp_clr, wp_clr;

  // the acknowledge goes to whichever request is presented, breakpoint first
  assign bp_clr = req_ack & bp_pend;
  assign wp_clr = req_ack & ~bp_pend & wp_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_pend <= 1'b0;
      wp_pend <= 1'b0;
    end else begin
      bp_pend <= (bp_pend & ~bp_clr) | bp_set;
      wp_pend <= (wp_pend & ~wp_clr) | wp_set;
    end
  end

  assign bp_req = bp_pend;
  assign wp_req = wp_pend & ~bp_pend;
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int SEL_W  = $clog2(NUM_BP + NUM_WP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              req_ack,
  output logic              bp_req,
  output logic              wp_req,
  output logic              stall_access
);
  localparam int MODE_W   = 2 * NUM_WP;
  localparam int WP_BASE  = NUM_BP;
  localparam int MODE_SEL = NUM_BP + NUM_WP;

  logic [ADDR_W-1:0] bp_slot_q [NUM_BP];
  logic [ADDR_W-1:0] wp_addr_q [NUM_WP];
  logic [MODE_W-1:0] wp_mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BP; i++) bp_slot_q[i] <= '0;
      for (int j = 0; j < NUM_WP; j++) wp_addr_q[j] <= '0;
      wp_mode_q <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_BP; i++)
        if (cfg_sel == SEL_W'(i)) bp_slot_q[i] <= cfg_wdata;
      for (int j = 0; j < NUM_WP; j++)
        if (cfg_sel == SEL_W'(WP_BASE + j)) wp_addr_q[j] <= cfg_wdata;
      if (cfg_sel == SEL_W'(MODE_SEL)) wp_mode_q <= cfg_wdata[MODE_W-1:0];
    end
  end

  logic [NUM_BP-1:0] bp_hit;
  logic [NUM_WP-1:0] wp_hit;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    dbg_bp_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .slot_reg    (bp_slot_q[g]),
      .fetch_valid (fetch_valid),
      .fetch_pc    (fetch_pc),
      .hit         (bp_hit[g])
    );
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    dbg_wp_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .mode     (wp_mode_e'(wp_mode_q[2*g +: 2])),
      .addr_reg (wp_addr_q[g]),
      .mem_addr (mem_addr),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr),
      .hit      (wp_hit[g])
    );
  end

  logic any_bp, any_wp, wp_pend;
  assign any_bp = |bp_hit;
  assign any_wp = |wp_hit;

  dbg_req_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .bp_set  (any_bp),
    .wp_set  (any_wp),
    .req_ack (req_ack),
    .bp_req  (bp_req),
    .wp_req  (wp_req),
    .wp_pend (wp_pend)
  );

  // combinational so the access is held in the cycle it would complete
  assign stall_access = any_wp | wp_pend;
endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk (
  input logic clk,
  input logic rst,
  input logic fetch_valid,
  input logic mem_rd,
  input logic mem_wr,
  input logic req_ack,
  input logic bp_req,
  input logic wp_req,
  input logic stall_access
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (!bp_req && !wp_req));
  // R7
  a_r7_bp_hold: assert property (@(posedge clk) disable iff (rst)
    (bp_req && !req_ack) |=> bp_req);
  // R7
  a_r7_wp_hold: assert property (@(posedge clk) disable iff (rst)
    (wp_req && !req_ack) |=> (wp_req || bp_req));
  // R8
  a_r8_bp_first: assert property (@(posedge clk) disable iff (rst)
    bp_req |-> !wp_req);
  // R6
  a_r6_stall_pending: assert property (@(posedge clk) disable iff (rst)
    wp_req |-> stall_access);
  // R2
  a_r2_bp_from_fetch: assert property (@(posedge clk) disable iff (rst)
    $rose(bp_req) |-> $past(fetch_valid));
  // R3
  a_r3_wp_from_access: assert property (@(posedge clk) disable iff (rst)
    $rose(wp_req) |-> ($past(mem_rd || mem_wr) || $past(bp_req)));
endmodule

bind dbg_match_unit dbg_match_unit_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .fetch_valid  (fetch_valid),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .req_ack      (req_ack),
  .bp_req       (bp_req),
  .wp_req       (wp_req),
  .stall_access (stall_access)
);

// File: tb/dbg_match_unit_test.sv
`timescale 1ns/1ps
module dbg_match_unit_test;
  localparam int AW = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic [AW-1:0] mem_addr = '0;
  logic mem_rd = 1'b0, mem_wr = 1'b0, req_ack = 1'b0;
  logic bp_req, wp_req, stall_access;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbg_match_unit uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .req_ack(req_ack),
    .bp_req(bp_req), .wp_req(wp_req), .stall_access(stall_access)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [SW-1:0] sel, input logic [AW-1:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic idle_bus();
    fetch_valid = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0;
  endtask

  task automatic drain();
    idle_bus();
    req_ack = 1'b1;
    tick(); tick();
    req_ack = 1'b0;
  endtask

  // fields: fv, pc, rd, wr, addr, exp_stall, exp_bp, exp_wp
  localparam logic [69:0] VEC [15] = '{
    {1'b1, 32'h0000_0100, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0}, // R2 slot 0
    {1'b1, 32'h0000_0200, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0}, // R2 slot 1
    {1'b1, 32'h0000_0104, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R2 miss
    {1'b1, 32'h0000_0300, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R5 disarmed bp
    {1'b0, 32'h0000_0100, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R2 no valid
    {1'b1, 32'h0000_0101, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R2 odd pc
    {1'b0, 32'h0, 1'b1, 1'b0, 32'h0000_1000, 1'b1, 1'b0, 1'b1}, // R3 read slot read
    {1'b0, 32'h0, 1'b0, 1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b0}, // R3 read slot write
    {1'b0, 32'h0, 1'b0, 1'b1, 32'h0000_1001, 1'b1, 1'b0, 1'b1}, // R3 write slot write
    {1'b0, 32'h0, 1'b1, 1'b0, 32'h0000_1001, 1'b0, 1'b0, 1'b0}, // R3 write slot read
    {1'b0, 32'h0, 1'b1, 1'b0, 32'h0000_1002, 1'b1, 1'b0, 1'b1}, // R3 both, read
    {1'b0, 32'h0, 1'b0, 1'b1, 32'h0000_1002, 1'b1, 1'b0, 1'b1}, // R3 both, write
    {1'b0, 32'h0, 1'b1, 1'b1, 32'h0000_1003, 1'b0, 1'b0, 1'b0}, // R5 mode off
    {1'b0, 32'h0, 1'b1, 1'b0, 32'h0000_1004, 1'b0, 1'b0, 1'b0}, // R4 neighbour
    {1'b0, 32'h0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0}  // R4 zero address
  };

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick();
    check("R1 bp_req in reset", bp_req, 1'b0);
    check("R1 wp_req in reset", wp_req, 1'b0);
    check("R1 stall in reset", stall_access, 1'b0);
    rst = 1'b0;
    // R1: slots disarmed after reset, nothing may match
    fetch_valid = 1'b1; fetch_pc = 32'h0; mem_rd = 1'b1; mem_addr = 32'h0;
    #1 check("R1 no stall with reset slots", stall_access, 1'b0);
    tick();
    check("R1 no bp with reset slots", bp_req, 1'b0);
    check("R1 no wp with reset slots", wp_req, 1'b0);
    idle_bus();

    // R10 register map
    cfg_write(4'd0, 32'h0000_0101);
    cfg_write(4'd1, 32'h0000_0201);
    cfg_write(4'd2, 32'h0000_0300);
    cfg_write(4'd4, 32'h0000_1000);
    cfg_write(4'd5, 32'h0000_1001);
    cfg_write(4'd6, 32'h0000_1002);
    cfg_write(4'd7, 32'h0000_1003);
    cfg_write(4'd8, 32'h0000_0039);

    for (int k = 0; k < 15; k++) begin
      logic [69:0] v;
      v = VEC[k];
      fetch_valid = v[69]; fetch_pc = v[68:37];
      mem_rd = v[36]; mem_wr = v[35]; mem_addr = v[34:3];
      #1 check($sformatf("R6 vec%0d stall", k), stall_access, v[2]);
      tick();
      idle_bus();
      check($sformatf("R2 vec%0d bp_req", k), bp_req, v[1]);
      check($sformatf("R3 vec%0d wp_req", k), wp_req, v[0]);
      drain();
    end

    // R7 and R6: hold while unacknowledged
    mem_rd = 1'b1; mem_addr = 32'h0000_1000;
    tick(); idle_bus();
    tick(); tick();
    check("R7 wp held", wp_req, 1'b1);
    check("R6 stall while pending", stall_access, 1'b1);
    req_ack = 1'b1; tick(); req_ack = 1'b0;
    check("R7 wp cleared by ack", wp_req, 1'b0);
    check("R6 stall released", stall_access, 1'b0);

    fetch_valid = 1'b1; fetch_pc = 32'h0000_0200;
    tick(); idle_bus(); tick(); tick();
    check("R7 bp held", bp_req, 1'b1);
    drain();

    // R8 same-cycle breakpoint and watchpoint
    fetch_valid = 1'b1; fetch_pc = 32'h0000_0100;
    mem_rd = 1'b1; mem_addr = 32'h0000_1000;
    #1 check("R8 stall at once", stall_access, 1'b1);
    tick(); idle_bus();
    check("R8 bp shown first", bp_req, 1'b1);
    check("R8 wp hidden", wp_req, 1'b0);
    req_ack = 1'b1; tick(); req_ack = 1'b0;
    check("R8 bp cleared", bp_req, 1'b0);
    check("R8 wp shown next", wp_req, 1'b1);
    req_ack = 1'b1; tick(); req_ack = 1'b0;
    check("R8 wp cleared", wp_req, 1'b0);

    // R9 clearing a disarmed slot
    cfg_write(4'd2, 32'h0000_0000);
    fetch_valid = 1'b1; fetch_pc = 32'h0000_0100;
    tick(); idle_bus();
    check("R9 other slot still hits", bp_req, 1'b1);
    drain();
    fetch_valid = 1'b1; fetch_pc = 32'h0000_0000;
    tick(); idle_bus();
    check("R9 cleared slot silent", bp_req, 1'b0);

    // R5 and R10: turn all watch modes off
    cfg_write(4'd8, 32'h0000_0000);
    mem_rd = 1'b1; mem_addr = 32'h0000_1000;
    #1 check("R5 mode off no stall", stall_access, 1'b0);
    tick(); idle_bus();
    check("R5 mode off no wp", wp_req, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule